// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block decides when a small 8-bit processor with a 16-bit program counter takes an interrupt, and then runs the entry sequence on the processor's behalf. Eight request lines are qualified by a global enable bit and by one enable bit per line. The decision is made only when the processor signals an instruction boundary. When the lowest-numbered qualified line is accepted, the block latches that line, the current PC and the stack pointer. It then drives the memory bus to save the return address in the same way a subroutine call does.

The parameter `VECTOR_TABLE` selects how the handler is reached. When it is 1, the block reads a two-byte little-endian pointer from a table in memory and loads it into the PC. When it is 0, the block loads the PC directly with a fixed slot address for the line, and a jump stored in that slot leads to the real handler. At the end the block presents the new PC and the decremented stack pointer for one cycle with load strobes, and the processor takes them over.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `busy`, `mem_we`, `mem_re`, `pc_load`, `sp_load`, `gie_clear` are low and `irq_ack` is all zero.
- R2: A line is accepted only if `irq_req[n]`, `gie` and `irq_mask[n]` are all high at a rising edge where `insn_boundary` is high. A mask bit of 1 enables the line. If no line qualifies, `busy` stays low.
- R3: When several qualified lines are pending, the one with the lowest index is serviced.
- R4: In the first busy cycle, `gie_clear` is high for exactly one cycle, and `irq_ack` carries a single 1 at the bit of the serviced line for that same cycle.
- R5: In the first busy cycle the block writes PC[15:8] to address SP-1. In the second busy cycle it writes PC[7:0] to address SP-2. Addresses wrap modulo 2^16.
- R6: In the final busy cycle, `sp_load` and `pc_load` are high together, and `sp_new` equals SP-2 (modulo 2^16).
- R7: With VECTOR_TABLE=1, the third busy cycle reads address BASE+2n and the fourth reads BASE+2n+1. Read data is valid on `mem_rdata` in the cycle after the read strobe. `pc_new` equals {byte at BASE+2n+1, byte at BASE+2n}, and the sequence lasts five cycles.
- R8: With VECTOR_TABLE=0, no read is issued, `pc_new` equals BASE+4n, and the sequence lasts three cycles.
- R9: `busy` is high for the entire sequence. While busy, changes on the requests, mask, enable and boundary inputs start no new sequence and do not change the serviced line.
- R10: While `insn_boundary` is low, no request is accepted even if it qualifies otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 8 | Interrupt request lines |
| irq_mask | input | 8 | Per-line enable, 1 = enabled |
| gie | input | 1 | Global interrupt enable |
| insn_boundary | input | 1 | High when the processor is between instructions |
| pc_in | input | 16 | Current program counter |
| sp_in | input | 16 | Current stack pointer |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_re` |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 8 | Bus write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| pc_load | output | 1 | Load `pc_new` into the PC |
| pc_new | output | 16 | Handler address |
| sp_load | output | 1 | Load `sp_new` into the stack pointer |
| sp_new | output | 16 | Stack pointer after the push |
| gie_clear | output | 1 | Clear the global enable |
| irq_ack | output | 8 | One-hot acknowledge of the serviced line |
| busy | output | 1 | Sequence in progress |

## Verification
Arbitration and gating act in the same cycle. A lower line can be pending but masked while a higher line is enabled, and the accepted line must then be the lowest one that passes its mask. The bench provokes this with request and mask patterns that overlap, applied in a single boundary cycle. It judges the result by the acknowledge bit and by the table address used for the handler. A second collision occurs when a fresh request, together with enable and boundary, arrives while a sequence is still running. The bench checks that the scoreboard sees no extra bus traffic and that the serviced line does not change.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int          NUM_LINES    = 8,
  parameter bit          VECTOR_TABLE = 1'b1,
  parameter logic [15:0] TABLE_BASE   = 16'hFFE0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_req,
  input  logic [NUM_LINES-1:0] irq_mask,
  input  logic                 gie,
  input  logic                 insn_boundary,
  input  logic [15:0]          pc_in,
  input  logic [15:0]          sp_in,
  input  logic [7:0]           mem_rdata,
  output logic [15:0]          mem_addr,
  output logic [7:0]           mem_wdata,
  output logic                 mem_we,
  output logic                 mem_re,
  output logic                 pc_load,
  output logic [15:0]          pc_new,
  output logic                 sp_load,
  output logic [15:0]          sp_new,
  output logic                 gie_clear,
  output logic [NUM_LINES-1:0] irq_ack,
  output logic                 busy
);
  localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  typedef enum logic [2:0] {S_IDLE, S_PUSH_HI, S_PUSH_LO, S_RD_LO, S_RD_HI, S_DONE} state_t;

  state_t         state;
  logic [LW-1:0]  line_q, sel;
  logic [15:0]    pc_q, sp_q;
  logic [7:0]     lo_q;
  logic [NUM_LINES-1:0] pending;
  logic           take;

  assign pending = irq_req & irq_mask;
  assign take    = (state == S_IDLE) && insn_boundary && gie && (|pending);

  always_comb begin
    sel = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--)
      if (pending[i]) sel = LW'(i);
  end

  wire [15:0] vec_addr  = TABLE_BASE + (16'(line_q) << 1);
  wire [15:0] slot_addr = TABLE_BASE + (16'(line_q) << 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      line_q <= '0;
      pc_q   <= '0;
      sp_q   <= '0;
      lo_q   <= '0;
    end else begin
      case (state)
        S_IDLE: if (take) begin
          state  <= S_PUSH_HI;
          line_q <= sel;
          pc_q   <= pc_in;
          sp_q   <= sp_in;
        end
        S_PUSH_HI: state <= S_PUSH_LO;
        S_PUSH_LO: state <= VECTOR_TABLE ? S_RD_LO : S_DONE;
        S_RD_LO:   state <= S_RD_HI;
        S_RD_HI: begin
          lo_q  <= mem_rdata;
          state <= S_DONE;
        end
        default:   state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state)
      S_PUSH_HI: mem_addr = sp_q - 16'd1;
      S_PUSH_LO: mem_addr = sp_q - 16'd2;
      S_RD_LO:   mem_addr = vec_addr;
      S_RD_HI:   mem_addr = vec_addr + 16'd1;
      default:   mem_addr = '0;
    endcase
  end

  assign mem_wdata = (state == S_PUSH_HI) ? pc_q[15:8] : (state == S_PUSH_LO) ? pc_q[7:0] : 8'h00;
  assign mem_we    = (state == S_PUSH_HI) || (state == S_PUSH_LO);
  assign mem_re    = (state == S_RD_LO) || (state == S_RD_HI);
  assign pc_load   = (state == S_DONE);
  assign sp_load   = (state == S_DONE);
  assign pc_new    = VECTOR_TABLE ? {mem_rdata, lo_q} : slot_addr;
  assign sp_new    = sp_q - 16'd2;
  assign gie_clear = (state == S_PUSH_HI);
  assign irq_ack   = (state == S_PUSH_HI) ? (NUM_LINES'(1) << line_q) : '0;
  assign busy      = (state != S_IDLE);

  p_accept_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(gie && insn_boundary && (|(irq_req & irq_mask))));

  p_ack_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_ack) && ((|irq_ack) == gie_clear));

  p_push_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |=> mem_we && (mem_addr == $past(mem_addr) - 16'd1));

  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re) && !(pc_load && (mem_we || mem_re)));

  p_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !busy);

  p_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> gie_clear && mem_we);
endmodule

// File: tb/test_irq_entry_seq.sv
`timescale 1ns/1ps
module test_irq_entry_seq;
  localparam logic [15:0] VB = 16'hFFE0;
  localparam logic [15:0] JB = 16'h0040;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [7:0] irq_req = '0, irq_mask = '0;
  logic gie = 1'b0, bnd = 1'b0;
  logic [15:0] pc_in = '0, sp_in = '0;

  logic [7:0]  rd_v = '0;
  logic [15:0] addr_v, addr_j, pcn_v, pcn_j, spn_v, spn_j;
  logic [7:0]  wd_v, wd_j, ack_v, ack_j;
  logic we_v, we_j, re_v, re_j, pl_v, pl_j, sl_v, sl_j, gc_v, gc_j, busy_v, busy_j;

  irq_entry_seq #(.VECTOR_TABLE(1'b1), .TABLE_BASE(VB)) i_irq_entry_seq (
    .clk, .rst_n, .irq_req, .irq_mask, .gie, .insn_boundary(bnd), .pc_in, .sp_in,
    .mem_rdata(rd_v), .mem_addr(addr_v), .mem_wdata(wd_v), .mem_we(we_v), .mem_re(re_v),
    .pc_load(pl_v), .pc_new(pcn_v), .sp_load(sl_v), .sp_new(spn_v), .gie_clear(gc_v),
    .irq_ack(ack_v), .busy(busy_v));

  irq_entry_seq #(.VECTOR_TABLE(1'b0), .TABLE_BASE(JB)) i_irq_entry_seq_jt (
    .clk, .rst_n, .irq_req, .irq_mask, .gie, .insn_boundary(bnd), .pc_in, .sp_in,
    .mem_rdata(8'h00), .mem_addr(addr_j), .mem_wdata(wd_j), .mem_we(we_j), .mem_re(re_j),
    .pc_load(pl_j), .pc_new(pcn_j), .sp_load(sl_j), .sp_new(spn_j), .gie_clear(gc_j),
    .irq_ack(ack_j), .busy(busy_j));

  always_ff @(posedge clk) if (re_v) rd_v <= addr_v[7:0] ^ 8'hA5;

  int checks = 0, errors = 0;
  logic [33:0] qv[$], qj[$];

  task automatic chk(input bit ok, input string req, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [1:0] k);
    return (k == 2'd1) ? "R5" : (k == 2'd2) ? "R7" : "R6/R7/R8";
  endfunction

  always @(negedge clk) if (rst_n) begin
    logic [33:0] o, e;
    for (int s = 0; s < 2; s++) begin
      for (int k = 1; k <= 3; k++) begin
        bit hit;
        if (s == 0) begin
          hit = (k == 1) ? we_v : (k == 2) ? re_v : pl_v;
          o = (k == 1) ? {2'd1, addr_v, 8'h00, wd_v} : (k == 2) ? {2'd2, addr_v, 16'h0} : {2'd3, pcn_v, spn_v};
        end else begin
          hit = (k == 1) ? we_j : (k == 2) ? re_j : pl_j;
          o = (k == 1) ? {2'd1, addr_j, 8'h00, wd_j} : (k == 2) ? {2'd2, addr_j, 16'h0} : {2'd3, pcn_j, spn_j};
        end
        if (hit) begin
          if (s == 0 && qv.size() == 0) chk(0, "R9 unexpected bus item", o, 34'h0);
          else if (s == 1 && qj.size() == 0) chk(0, "R9 unexpected bus item", o, 34'h0);
          else begin
            e = (s == 0) ? qv.pop_front() : qj.pop_front();
            chk(o == e, tag_of(e[33:32]), o, e);
            if (k == 3) chk((s == 0) ? sl_v : sl_j, "R6 sp_load with pc_load", 34'h0, 34'h1);
          end
        end
      end
    end
  end

  task automatic entry(input logic [7:0] req, input logic [7:0] msk, input bit g, input bit b,
                       input logic [15:0] pc, input logic [15:0] sp, input int line, input bit hold);
    @(negedge clk);
    if (line >= 0) begin
      logic [15:0] va;
      va = VB + 16'(line * 2);
      qv.push_back({2'd1, sp - 16'd1, 8'h00, pc[15:8]});
      qv.push_back({2'd1, sp - 16'd2, 8'h00, pc[7:0]});
      qv.push_back({2'd2, va, 16'h0});
      qv.push_back({2'd2, va + 16'd1, 16'h0});
      qv.push_back({2'd3, {(va[7:0] + 8'd1) ^ 8'hA5, va[7:0] ^ 8'hA5}, sp - 16'd2});
      qj.push_back({2'd1, sp - 16'd1, 8'h00, pc[15:8]});
      qj.push_back({2'd1, sp - 16'd2, 8'h00, pc[7:0]});
      qj.push_back({2'd3, JB + 16'(line * 4), sp - 16'd2});
    end
    irq_req = req; irq_mask = msk; gie = g; bnd = b; pc_in = pc; sp_in = sp;
    @(negedge clk);
    irq_req = '0; gie = 1'b0; bnd = 1'b0;
    if (line >= 0) begin
      chk(busy_v && busy_j, "R9 busy at start", {32'h0, busy_v, busy_j}, 34'h3);
      chk(ack_v == (8'h1 << line), "R3/R4 ack vector", 34'(ack_v), 34'(8'h1 << line));
      chk(ack_j == (8'h1 << line), "R3/R4 ack jump", 34'(ack_j), 34'(8'h1 << line));
      chk(gc_v && gc_j, "R4 gie_clear", {32'h0, gc_v, gc_j}, 34'h3);
      if (hold) begin
        irq_req = 8'hFF; irq_mask = 8'hFF; gie = 1'b1; bnd = 1'b1;
        @(negedge clk);
        irq_req = '0; gie = 1'b0; bnd = 1'b0;
        chk(ack_v == 0 && !gc_v, "R4 one-cycle pulse", 34'(ack_v), 34'h0);
        chk(busy_v && busy_j, "R9 busy mid-sequence", {32'h0, busy_v, busy_j}, 34'h3);
      end
    end else begin
      chk(!busy_v && !busy_j, "R2/R10 no acceptance", {32'h0, busy_v, busy_j}, 34'h0);
      chk(ack_v == 0 && ack_j == 0, "R2/R10 no ack", {18'h0, ack_v, ack_j}, 34'h0);
    end
    repeat (7) @(negedge clk);
    chk(!busy_v && !busy_j, "R9 idle after sequence", {32'h0, busy_v, busy_j}, 34'h0);
    chk(qv.size() == 0 && qj.size() == 0, "R7/R8 all items seen", 34'(qv.size() + qj.size()), 34'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_v && !we_v && !re_v && !pl_v && !sl_v && !gc_v && ack_v == 0, "R1 reset vector",
        {27'h0, busy_v, we_v, re_v, pl_v, sl_v, gc_v, |ack_v}, 34'h0);
    chk(!busy_j && !we_j && !re_j && !pl_j && !sl_j && !gc_j && ack_j == 0, "R1 reset jump",
        {27'h0, busy_j, we_j, re_j, pl_j, sl_j, gc_j, |ack_j}, 34'h0);
    rst_n = 1'b1;
    entry(8'h01, 8'hFF, 1, 1, 16'h1234, 16'h8000, 0, 0);
    entry(8'hA0, 8'hFF, 1, 1, 16'hBEEF, 16'h7F00, 5, 0);
    entry(8'h0C, 8'hFB, 1, 1, 16'h0102, 16'h4000, 3, 0);
    entry(8'hFF, 8'hFF, 0, 1, 16'h0000, 16'h4000, -1, 0);
    entry(8'h0F, 8'hF0, 1, 1, 16'h0000, 16'h4000, -1, 0);
    entry(8'h10, 8'hFF, 1, 0, 16'h0000, 16'h4000, -1, 0);
    entry(8'h80, 8'hFF, 1, 1, 16'hC0DE, 16'h2000, 7, 1);
    entry(8'h42, 8'hFF, 1, 1, 16'hFFFF, 16'h0001, 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule